// File: doc/BRIEF.md
# Variable Page Size Translation Buffer

This block is a software-managed address translation buffer of 64 entries, shared by instruction and data accesses. Each entry has two 32-bit words: a tag word with the effective page number, a 3-bit page-size code and a valid flag, and a data word with the real page number, execute and write permission bits, a zone select field and four memory attribute bits. Software fills, reads back and searches the entries through index-addressed ports. The hardware never loads an entry on its own.

Every entry sets its own page size, from 1 KiB up to 16 MiB in steps of four. The size code decides how many effective-address bits take part in the compare and where the real page number is joined to the page offset. A translation port checks all entries in parallel. It picks the lowest matching index, builds the physical address and checks execute and write permission for the access kind. One cycle later it returns a registered hit, fault, physical address and attribute nibble. A search port returns a found flag and the index of the lowest matching entry.

Index 63 is normally kept by software as a scratch mapping, and a few low indices may be reserved. The block treats all indices the same; keeping those entries intact is up to software.

Top module: `vps_tlb`

## Requirements
- R1: While `rst` is high at a clock edge, all entries are cleared to zero (invalid), and after that edge every registered output (`rd_word`, `srch_found`, `srch_idx`, `xl_pa`, `xl_attr`, `xl_hit`, `xl_fault`) is zero.
- R2: With `wr_en` high, `wr_word` is stored at entry `wr_idx`: into the tag word when `wr_sel`=0 and into the data word when `wr_sel`=1. One cycle after `rd_idx`/`rd_sel` are presented, `rd_word` shows that word as it stood before any write at the same edge. Bit 6 of the tag word read back is the current valid flag.
- R3: An entry matches an effective address only when its tag bit 6 (valid) is set and tag bits 31 down to 10+2n equal the same address bits. Here n is tag bits 9:7, and codes 0..7 mean page sizes 1K, 4K, 16K, 64K, 256K, 1M, 4M and 16M.
- R4: On a hit, `xl_pa` is data-word bits 31 down to 10+2n joined to effective-address bits 9+2n down to 0, and `xl_attr` is data-word bits 3:0. Both appear one cycle after `xl_va`/`xl_kind` are presented, and both are zero when `xl_hit` is low.
- R5: `xl_kind` 2'b00 is a fetch and needs data bit 9 (execute). 2'b10 is a write and needs data bit 8 (write). 2'b01 and 2'b11 are reads and never fault. A denied access sets `xl_fault`, clears `xl_hit` and zeroes `xl_pa` and `xl_attr`. A miss sets neither flag.
- R6: When several entries match, the lowest index alone decides the address, the attributes and the permission result.
- R7: When `srch_req` is high, one cycle later `srch_found` shows whether any entry matches `srch_va` (rule of R3) and `srch_idx` holds the lowest matching index, or 0 on a miss. Without a request both outputs hold.
- R8: A write to either word of an entry takes effect for a translation presented in the very next cycle.
- R9: `inv_all` clears the valid flag of every entry at one edge. A tag write at the same edge is applied on top and keeps its own valid bit.
- R10: The zone select bits 7:4 of the data word are stored and read back but have no effect on hit, fault, address or attributes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Entry word write strobe |
| wr_idx | input | 6 | Entry index to write |
| wr_sel | input | 1 | 0 = tag word, 1 = data word |
| wr_word | input | 32 | Value to write |
| inv_all | input | 1 | Clear every valid flag |
| rd_idx | input | 6 | Entry index to read back |
| rd_sel | input | 1 | 0 = tag word, 1 = data word |
| rd_word | output | 32 | Registered readback word |
| srch_req | input | 1 | Search request |
| srch_va | input | 32 | Effective address to search for |
| srch_found | output | 1 | Search found a matching entry |
| srch_idx | output | 6 | Lowest matching index |
| xl_va | input | 32 | Effective address to translate |
| xl_kind | input | 2 | Access kind: 00 fetch, 01/11 read, 10 write |
| xl_pa | output | 32 | Physical address |
| xl_attr | output | 4 | Attribute bits of the winning entry |
| xl_hit | output | 1 | Translation succeeded |
| xl_fault | output | 1 | Matching entry denies the access |

## Verification
On every cycle the assertions check that hit and fault never appear together, that the address and attributes are zero whenever hit is low, that search results hold between requests, that an invalidate with no write at the same edge leaves no hit two cycles later, and that reset clears the outputs. The choice of the lowest index among overlapping entries, the bit position of the join at each of the eight page sizes, the permission result for each access kind, and write-then-translate timing can be shown only by the bench. Its reference model recomputes every output from its own copy of the entries on every clock, and directed scenarios add hand-worked values.

// File: rtl/vps_tlb_pkg.sv
package vps_tlb_pkg;
  // Word layout; positions are decoded by the match and splice logic.
  localparam int WORD_W    = 32;
  localparam int BASE_SH   = 10;   // smallest page is 1 KiB
  localparam int SZ_HI     = 9;
  localparam int SZ_LO     = 7;
  localparam int VLD_BIT   = 6;
  localparam int EXE_BIT   = 9;
  localparam int WRT_BIT   = 8;
  localparam int ATTR_W    = 4;

  typedef enum logic [1:0] {
    KIND_FETCH = 2'b00,
    KIND_READ  = 2'b01,
    KIND_WRITE = 2'b10,
    KIND_READB = 2'b11
  } acc_kind_e;

  // Mask of the address bits that belong to the page number for a size code.
  function automatic logic [WORD_W-1:0] page_keep(input logic [2:0] code);
    page_keep = {WORD_W{1'b1}} << (BASE_SH + 2 * int'(code));
  endfunction
endpackage

// File: rtl/vps_tlb_store.sv
module vps_tlb_store
  import vps_tlb_pkg::*;
#(
  parameter int ENTRIES = 64,
  localparam int IW = $clog2(ENTRIES)
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            wr_en,
  input  logic [IW-1:0]                   wr_idx,
  input  logic                            wr_sel,
  input  logic [WORD_W-1:0]               wr_word,
  input  logic                            inv_all,
  input  logic [IW-1:0]                   rd_idx,
  input  logic                            rd_sel,
  output logic [WORD_W-1:0]               rd_word,
  output logic [ENTRIES-1:0][WORD_W-1:0]  tags,
  output logic [ENTRIES-1:0][WORD_W-1:0]  datas
);
  logic [ENTRIES-1:0][WORD_W-1:0] tag_r;
  logic [ENTRIES-1:0][WORD_W-1:0] data_r;

  always_ff @(posedge clk) begin
    if (rst) begin
      tag_r   <= '0;
      data_r  <= '0;
      rd_word <= '0;
    end else begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (inv_all) tag_r[i][VLD_BIT] <= 1'b0;
        if (wr_en && wr_idx == IW'(i)) begin
          if (!wr_sel) tag_r[i]  <= wr_word;
          else         data_r[i] <= wr_word;
        end
      end
      rd_word <= rd_sel ? data_r[rd_idx] : tag_r[rd_idx];
    end
  end

  assign tags  = tag_r;
  assign datas = data_r;
endmodule

// File: rtl/vps_tlb_match.sv
module vps_tlb_match
  import vps_tlb_pkg::*;
#(
  parameter int ENTRIES = 64,
  localparam int IW = $clog2(ENTRIES)
) (
  input  logic [WORD_W-1:0]               va,
  input  logic [ENTRIES-1:0][WORD_W-1:0]  tags,
  output logic                            found,
  output logic [IW-1:0]                   idx
);
  logic [ENTRIES-1:0] mvec;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign mvec[g] = tags[g][VLD_BIT] &&
                     (((va ^ tags[g]) & page_keep(tags[g][SZ_HI:SZ_LO])) == '0);
  end

  // Lowest index wins: scan downward so the last assignment is the lowest.
  always_comb begin
    found = |mvec;
    idx   = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (mvec[i]) idx = IW'(i);
    end
  end
endmodule

// File: rtl/vps_tlb.sv
module vps_tlb
  import vps_tlb_pkg::*;
#(
  parameter int ENTRIES = 64,
  localparam int IW = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [IW-1:0]     wr_idx,
  input  logic              wr_sel,
  input  logic [31:0]       wr_word,
  input  logic              inv_all,
  input  logic [IW-1:0]     rd_idx,
  input  logic              rd_sel,
  output logic [31:0]       rd_word,
  input  logic              srch_req,
  input  logic [31:0]       srch_va,
  output logic              srch_found,
  output logic [IW-1:0]     srch_idx,
  input  logic [31:0]       xl_va,
  input  logic [1:0]        xl_kind,
  output logic [31:0]       xl_pa,
  output logic [3:0]        xl_attr,
  output logic              xl_hit,
  output logic              xl_fault
);
  logic [ENTRIES-1:0][WORD_W-1:0] tags;
  logic [ENTRIES-1:0][WORD_W-1:0] datas;
  logic              xm_found, sm_found;
  logic [IW-1:0]     xm_idx, sm_idx;
  logic [WORD_W-1:0] win_data, keep, pa_n;
  logic              deny, grant;
  acc_kind_e         kind;

  vps_tlb_store #(.ENTRIES(ENTRIES)) u_store (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx), .wr_sel(wr_sel),
    .wr_word(wr_word), .inv_all(inv_all), .rd_idx(rd_idx), .rd_sel(rd_sel),
    .rd_word(rd_word), .tags(tags), .datas(datas)
  );

  vps_tlb_match #(.ENTRIES(ENTRIES)) u_xmatch (
    .va(xl_va), .tags(tags), .found(xm_found), .idx(xm_idx)
  );

  vps_tlb_match #(.ENTRIES(ENTRIES)) u_smatch (
    .va(srch_va), .tags(tags), .found(sm_found), .idx(sm_idx)
  );

  always_comb begin
    kind     = acc_kind_e'(xl_kind);
    win_data = datas[xm_idx];
    keep     = page_keep(tags[xm_idx][SZ_HI:SZ_LO]);
    pa_n     = (win_data & keep) | (xl_va & ~keep);
    deny     = xm_found &&
               ((kind == KIND_FETCH && !win_data[EXE_BIT]) ||
                (kind == KIND_WRITE && !win_data[WRT_BIT]));
    grant    = xm_found && !deny;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      xl_pa      <= '0;
      xl_attr    <= '0;
      xl_hit     <= 1'b0;
      xl_fault   <= 1'b0;
      srch_found <= 1'b0;
      srch_idx   <= '0;
    end else begin
      xl_hit   <= grant;
      xl_fault <= deny;
      xl_pa    <= grant ? pa_n : '0;
      xl_attr  <= grant ? win_data[ATTR_W-1:0] : '0;
      if (srch_req) begin
        srch_found <= sm_found;
        srch_idx   <= sm_idx;
      end
    end
  end
endmodule

// File: rtl/vps_tlb_chk.sv
module vps_tlb_chk #(
  parameter int IW = 6
) (
  input logic          clk,
  input logic          rst,
  input logic          wr_en,
  input logic          inv_all,
  input logic          srch_req,
  input logic          srch_found,
  input logic [IW-1:0] srch_idx,
  input logic [31:0]   xl_pa,
  input logic [3:0]    xl_attr,
  input logic          xl_hit,
  input logic          xl_fault
);
  // R1
  rst_clear_chk: assert property (@(posedge clk)
    rst |=> (!xl_hit && !xl_fault && !srch_found && xl_pa == '0 && xl_attr == '0));

  // R5
  hit_fault_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(xl_hit && xl_fault));

  // R4
  miss_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !xl_hit |-> (xl_pa == '0 && xl_attr == '0));

  // R7
  search_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(srch_req) |-> ($stable(srch_found) && $stable(srch_idx)));

  // R9
  inv_no_hit_chk: assert property (@(posedge clk) disable iff (rst)
    (inv_all && !wr_en) |-> ##2 !xl_hit);
endmodule

bind vps_tlb vps_tlb_chk #(.IW(IW)) u_chk (.*);

// File: tb/sim_vps_tlb.sv
`timescale 1ns/1ps
module sim_vps_tlb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 0, wr_sel = 0, inv_all = 0, rd_sel = 0, srch_req = 0;
  logic [5:0]  wr_idx = 0, rd_idx = 0;
  logic [31:0] wr_word = 0, srch_va = 0, xl_va = 0;
  logic [1:0]  xl_kind = 2'b01;
  logic [31:0] rd_word, xl_pa;
  logic        srch_found, xl_hit, xl_fault;
  logic [5:0]  srch_idx;
  logic [3:0]  xl_attr;

  int total = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  vps_tlb u0 (.*);

  // ---------------- reference model ----------------
  logic [31:0] mtag [64];
  logic [31:0] mdata [64];
  logic        e_hit, e_flt, e_sf;
  logic [31:0] e_pa, e_rd;
  logic [3:0]  e_at;
  logic [5:0]  e_si;

  function automatic void mfind(input logic [31:0] va, output bit got, output int win);
    got = 0; win = 0;
    for (int i = 0; i < 64; i++) begin
      if (!got && mtag[i][6]) begin
        int sz = 10 + 2 * int'(mtag[i][9:7]);
        if ((va >> sz) == (mtag[i] >> sz)) begin got = 1; win = i; end
      end
    end
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    bit in_rst;
    in_rst = rst;
    if (rst) begin
      for (int i = 0; i < 64; i++) begin mtag[i] = 0; mdata[i] = 0; end
      e_hit = 0; e_flt = 0; e_pa = 0; e_at = 0; e_sf = 0; e_si = 0; e_rd = 0;
    end else begin
      bit got; int w;
      mfind(xl_va, got, w);
      e_hit = 0; e_flt = 0; e_pa = 0; e_at = 0;
      if (got) begin
        bit bad;
        bad = (xl_kind == 2'b00 && !mdata[w][9]) || (xl_kind == 2'b10 && !mdata[w][8]);
        if (bad) e_flt = 1;
        else begin
          logic [31:0] off;
          off   = (32'd1 << (10 + 2 * int'(mtag[w][9:7]))) - 1;
          e_hit = 1;
          e_pa  = (mdata[w] & ~off) | (xl_va & off);
          e_at  = mdata[w][3:0];
        end
      end
      if (srch_req) begin
        mfind(srch_va, got, w);
        e_sf = got;
        e_si = got ? 6'(w) : 6'd0;
      end
      e_rd = rd_sel ? mdata[rd_idx] : mtag[rd_idx];
      if (inv_all) for (int i = 0; i < 64; i++) mtag[i][6] = 1'b0;
      if (wr_en) begin
        if (wr_sel) mdata[wr_idx] = wr_word;
        else        mtag[wr_idx]  = wr_word;
      end
    end
    #1;
    if (!done) begin
      chk({xl_hit, xl_fault} == {e_hit, e_flt}, in_rst ? "R1" : "R5", "hit/fault",
          {30'd0, xl_hit, xl_fault}, {30'd0, e_hit, e_flt});
      chk(xl_pa == e_pa && xl_attr == e_at, in_rst ? "R1" : "R4", "pa/attr",
          xl_pa ^ {28'd0, xl_attr}, e_pa ^ {28'd0, e_at});
      chk(srch_found == e_sf && srch_idx == e_si, in_rst ? "R1" : "R7", "search",
          {25'd0, srch_found, srch_idx}, {25'd0, e_sf, e_si});
      chk(rd_word == e_rd, in_rst ? "R1" : "R2", "readback", rd_word, e_rd);
    end
  end

  // ---------------- stimulus tasks ----------------
  task automatic wr(input int idx, input bit sel, input logic [31:0] w);
    @(negedge clk);
    wr_en = 1; wr_idx = 6'(idx); wr_sel = sel; wr_word = w;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic xl(input logic [31:0] va, input logic [1:0] k);
    @(negedge clk);
    xl_va = va; xl_kind = k;
    @(posedge clk); #1;
  endtask

  task automatic xchk(input string req, input bit h, input bit f,
                      input logic [31:0] pa, input logic [3:0] at);
    chk(xl_hit == h && xl_fault == f, req, "directed hit/fault",
        {30'd0, xl_hit, xl_fault}, {30'd0, h, f});
    chk(xl_pa == pa && xl_attr == at, req, "directed pa/attr",
        xl_pa ^ {28'd0, xl_attr}, pa ^ {28'd0, at});
  endtask

  task automatic srch(input logic [31:0] va);
    @(negedge clk);
    srch_req = 1; srch_va = va;
    @(posedge clk); #1;
    @(negedge clk);
    srch_req = 0;
  endtask

  task automatic rdb(input int idx, input bit sel);
    @(negedge clk);
    rd_idx = 6'(idx); rd_sel = sel;
    @(posedge clk); #1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      fails++; total++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    logic [31:0] lf;
    repeat (4) @(posedge clk);
    @(negedge clk); rst = 0;

    // R1: every entry is invalid after reset
    xl(32'h0000_0000, 2'b01); xchk("R1", 0, 0, 0, 0);

    wr(0, 0, 32'h1000_0440); wr(0, 1, 32'h8000_0305);
    wr(1, 0, 32'h2300_03C0); wr(1, 1, 32'h4500_020A);

    // R4: 1K page splice
    xl(32'h1000_07FF, 2'b01); xchk("R4", 1, 0, 32'h8000_03FF, 4'h5);
    // R4: 16M page splice, R5 read/write/fetch on execute-only entry
    xl(32'h23AB_CDEF, 2'b01); xchk("R4", 1, 0, 32'h45AB_CDEF, 4'hA);
    xl(32'h23AB_CDEF, 2'b10); xchk("R5", 0, 1, 0, 0);
    xl(32'h23AB_CDEF, 2'b00); xchk("R5", 1, 0, 32'h45AB_CDEF, 4'hA);
    xl(32'h23AB_CDEF, 2'b11); xchk("R5", 1, 0, 32'h45AB_CDEF, 4'hA);

    // R3: every size code, inside and just past the page
    for (int n = 0; n < 8; n++) begin
      logic [31:0] base, dat, m, va;
      base = 32'h4000_0000 + 32'(n) * 32'h0100_0000;
      dat  = (32'h9000_0000 + 32'(n) * 32'h0040_0000 + 32'h0001_2400) | 32'h300 | 32'(n);
      m    = (32'd1 << (10 + 2 * n)) - 1;
      wr(2 + n, 0, base | (32'(n) << 7) | 32'h40);
      wr(2 + n, 1, dat);
      va = base | (32'h00AB_CDEF & m);
      xl(va, 2'b10); xchk("R3", 1, 0, (dat & ~m) | (va & m), 4'(n));
      xl(base + m + 1, 2'b01); xchk("R3", 0, 0, 0, 0);
    end

    // R6, R10: overlapping 4K entries, zone bits set on the winner
    wr(10, 0, 32'h5000_00C0); wr(10, 1, 32'h0AAA_02F0);
    wr(11, 0, 32'h5000_00C0); wr(11, 1, 32'h0BBB_0300);
    xl(32'h5000_0123, 2'b01); xchk("R6", 1, 0, 32'h0AAA_0123, 4'h0);
    xl(32'h5000_0123, 2'b10); xchk("R6", 0, 1, 0, 0);
    xl(32'h5000_0123, 2'b00); xchk("R10", 1, 0, 32'h0AAA_0123, 4'h0);

    // R7: search hit with priority, then miss
    srch(32'h5000_0FFF);
    chk(srch_found && srch_idx == 6'd10, "R7", "search hit",
        {25'd0, srch_found, srch_idx}, {25'd0, 1'b1, 6'd10});
    srch(32'h7000_0000);
    chk(!srch_found && srch_idx == 6'd0, "R7", "search miss",
        {25'd0, srch_found, srch_idx}, 32'd0);

    // R2: readback of both words
    rdb(10, 1); chk(rd_word == 32'h0AAA_02F0, "R2", "data readback", rd_word, 32'h0AAA_02F0);
    rdb(10, 0); chk(rd_word == 32'h5000_00C0, "R2", "tag readback", rd_word, 32'h5000_00C0);

    // R5: fetch from an entry without execute
    wr(12, 0, 32'h6000_00C0); wr(12, 1, 32'h0CCC_0000);
    xl(32'h6000_0010, 2'b00); xchk("R5", 0, 1, 0, 0);
    xl(32'h6000_0010, 2'b01); xchk("R5", 1, 0, 32'h0CCC_0010, 4'h0);

    // Mixed traffic, checked by the reference model every clock
    lf = 32'hACE1_2345;
    for (int k = 0; k < 400; k++) begin
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      @(negedge clk);
      xl_va    = (32'h4000_0000 + 32'(k % 9) * 32'h0100_0000) | (lf & 32'h00FF_FFFF);
      xl_kind  = lf[1:0];
      srch_req = lf[5];
      srch_va  = {lf[15:8], lf[31:8]};
      rd_idx   = lf[13:8]; rd_sel = lf[14];
      if (k % 50 == 7) begin
        wr_en = 1; wr_idx = 6'(2 + (k % 8)); wr_sel = 1; wr_word = lf;
      end else wr_en = 0;
    end
    @(negedge clk); wr_en = 0; srch_req = 0;

    // R8: write then translate in the very next cycle
    @(negedge clk);
    wr_en = 1; wr_idx = 0; wr_sel = 1; wr_word = 32'h9000_0305;
    @(negedge clk);
    wr_en = 0; xl_va = 32'h1000_07FF; xl_kind = 2'b01;
    @(posedge clk); #1;
    xchk("R8", 1, 0, 32'h9000_03FF, 4'h5);

    // R9: invalidate alone
    @(negedge clk); inv_all = 1;
    @(negedge clk); inv_all = 0;
    xl(32'h1000_07FF, 2'b01); xchk("R9", 0, 0, 0, 0);
    rdb(0, 0); chk(rd_word == 32'h1000_0400, "R9", "valid cleared", rd_word, 32'h1000_0400);

    // R9: invalidate with a simultaneous tag write
    @(negedge clk);
    inv_all = 1; wr_en = 1; wr_idx = 12; wr_sel = 0; wr_word = 32'h6000_00C0;
    @(negedge clk);
    inv_all = 0; wr_en = 0;
    xl(32'h6000_0010, 2'b01); xchk("R9", 1, 0, 32'h0CCC_0010, 4'h0);
    xl(32'h23AB_CDEF, 2'b01); xchk("R9", 0, 0, 0, 0);

    repeat (3) @(posedge clk);
    #2;
    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule